// File: doc/BRIEF.md
# Privileged Model-Specific Register Access Checker

This block guards a small model-specific register file with two entries: an extended-feature register and a miscellaneous-enable register. Each request arrives with a valid strobe, a read/write flag, a register index, write data, the current privilege level and a virtual-8086 mode flag. The block judges the request in the same cycle it is presented. A legal read returns the register contents. A legal write updates the register at the next clock edge. An illegal request raises a general-protection fault with error code 0. Decoding the instruction and delivering the fault are left to the surrounding logic.

A request is illegal in any of four cases: the privilege level is not zero, the core is in virtual-8086 mode, the index names no implemented register, or a write sets a bit outside the writable mask of its target. A faulting request never changes any stored value and always returns zero read data. The no-execute enable bit of the extended-feature register is exported so that the page-walk logic can use it.

Top module: `msr_guard`

## Requirements
- R1: A valid request with `cur_pl` not equal to 0 raises `gp_fault` in the same cycle.
- R2: A valid request with `v86_mode` high raises `gp_fault` in the same cycle.
- R3: A valid request whose index is neither `EFR_INDEX` (default 8'h80) nor `MEN_INDEX` (default 8'h1A) raises `gp_fault`.
- R4: A valid write whose data has a bit set outside the target's writable mask raises `gp_fault`. The extended-feature mask defaults to 32'h0000_0801 (bit 11 is no-execute enable, bit 0 is also writable). The miscellaneous mask defaults to 32'h0000_00FF.
- R5: A faulting request leaves both registers unchanged.
- R6: While `gp_fault` is high, `rd_data` is zero.
- R7: A legal write is stored at the next rising clock edge. A legal read returns the current contents in the same cycle. `rd_data` is zero for writes and while no request is valid.
- R8: After reset both registers read zero. `nx_enable` always equals bit 11 of the extended-feature register.
- R9: `gp_fault` stays low while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 8 | Register index |
| req_wdata | input | 32 | Write data |
| cur_pl | input | 2 | Current privilege level |
| v86_mode | input | 1 | Virtual-8086 mode active |
| rd_data | output | 32 | Read data, zero unless this is a legal read |
| gp_fault | output | 1 | General-protection fault, error code 0 |
| nx_enable | output | 1 | No-execute enable bit of the extended-feature register |

## Verification
Two functions can fall in the same cycle: the fault decision and the register update. A write that is illegal must be refused in the very cycle it would otherwise commit. The bench provokes this with writes that are well formed in every respect but one: a reserved bit, a nonzero privilege level, or virtual-8086 mode. For each, it checks that the fault appears in that cycle. It then judges the outcome through a later legal read and through `nx_enable`, and both must show the earlier value.

// File: rtl/msr_guard_pkg.sv
package msr_guard_pkg;
  localparam int NREG   = 2;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  typedef enum int {
    SLOT_EFR = 0,
    SLOT_MEN = 1
  } slot_e;
endpackage

// File: rtl/msr_access_check.sv
module msr_access_check #(
  parameter int NREG   = 2,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter logic [NREG*IDX_W-1:0]  IDX_LIST  = '0,
  parameter logic [NREG*DATA_W-1:0] MASK_LIST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        pl,
  input  logic              v86,
  output logic [NREG-1:0]   hit,
  output logic              fault
);
  logic [DATA_W-1:0] mask_sel;
  logic              any_hit;
  logic              rsvd_set;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = (index == IDX_LIST[g*IDX_W +: IDX_W]);
  end

  always_comb begin
    mask_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) mask_sel = mask_sel | MASK_LIST[i*DATA_W +: DATA_W];
    end
  end

  assign any_hit  = |hit;
  assign rsvd_set = write && ((wdata & ~mask_sel) != '0);

  assign fault = valid && ((pl != 2'd0) || v86 || !any_hit || rsvd_set);

  AST_UNIMPL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (hit == '0)) |-> fault); // R3
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R3
endmodule

// File: rtl/msr_reg_bank.sv
module msr_reg_bank #(
  parameter int NREG     = 2,
  parameter int DATA_W   = 32,
  parameter int EXP_SLOT = 0,
  parameter int EXP_BIT  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NREG-1:0]   sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              exp_bit
);
  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] d [NREG];
  logic [NREG-1:0]   ce;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign ce[g] = wr_en && sel[g];

    always_comb begin
      d[g] = q[g];
      if (ce[g]) d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (ce[g]) q[g] <= d[g];
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce[g] |=> $stable(q[g])); // R5
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rdata = rdata | q[i];
    end
  end

  assign exp_bit = q[EXP_SLOT][EXP_BIT];
endmodule

// File: rtl/msr_guard.sv
module msr_guard
  import msr_guard_pkg::*;
#(
  parameter logic [IDX_W-1:0]  EFR_INDEX = 8'h80,
  parameter logic [IDX_W-1:0]  MEN_INDEX = 8'h1A,
  parameter logic [DATA_W-1:0] EFR_MASK  = 32'h0000_0801,
  parameter logic [DATA_W-1:0] MEN_MASK  = 32'h0000_00FF,
  parameter int                NX_BIT    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_pl,
  input  logic              v86_mode,
  output logic [DATA_W-1:0] rd_data,
  output logic              gp_fault,
  output logic              nx_enable
);
  localparam logic [NREG*IDX_W-1:0]  IDX_LIST  = {MEN_INDEX, EFR_INDEX};
  localparam logic [NREG*DATA_W-1:0] MASK_LIST = {MEN_MASK, EFR_MASK};

  logic              rst_meta_q, rst_sync_q;
  logic [NREG-1:0]   hit;
  logic              fault;
  logic              wr_ok;
  logic [DATA_W-1:0] bank_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  msr_access_check #(
    .NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .IDX_LIST(IDX_LIST), .MASK_LIST(MASK_LIST)
  ) chk_i (
    .clk(clk), .rst_n(rst_sync_q),
    .valid(req_valid), .write(req_write), .index(req_index),
    .wdata(req_wdata), .pl(cur_pl), .v86(v86_mode),
    .hit(hit), .fault(fault)
  );

  assign wr_ok = req_valid && req_write && !fault;

  msr_reg_bank #(
    .NREG(NREG), .DATA_W(DATA_W), .EXP_SLOT(SLOT_EFR), .EXP_BIT(NX_BIT)
  ) bank_i (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_en(wr_ok), .sel(hit), .wdata(req_wdata),
    .rdata(bank_rdata), .exp_bit(nx_enable)
  );

  assign gp_fault = fault;
  assign rd_data  = (req_valid && !req_write && !fault) ? bank_rdata : '0;

  AST_PL_FAULT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid && cur_pl != 2'd0) |-> gp_fault); // R1
  AST_V86_FAULT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid && v86_mode) |-> gp_fault); // R2
  AST_FAULT_KEEPS_NX: assert property (@(posedge clk) disable iff (!rst_sync_q)
    gp_fault |=> $stable(nx_enable)); // R5
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_q)
    gp_fault |-> (rd_data == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !req_valid |-> (!gp_fault && rd_data == '0)); // R9
endmodule

// File: tb/msr_guard_tb_top.sv
module msr_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, v86_mode;
  logic [7:0]  req_index;
  logic [31:0] req_wdata, rd_data;
  logic [1:0]  cur_pl;
  logic        gp_fault, nx_enable;
  int checks = 0, fails = 0;

  localparam logic [7:0] EFR = 8'h80, MEN = 8'h1A;

  always #5 clk = ~clk;

  msr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .cur_pl(cur_pl),
    .v86_mode(v86_mode), .rd_data(rd_data), .gp_fault(gp_fault),
    .nx_enable(nx_enable)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Presents one request; returns fault and read data seen before the edge.
  task automatic access(input logic wr, input logic [7:0] idx, input logic [31:0] wd,
                        input logic [1:0] pl, input logic v86,
                        output logic flt, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx;
    req_wdata = wd; cur_pl = pl; v86_mode = v86;
    #2;
    flt = gp_fault; rd = rd_data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    cur_pl = 2'd0; v86_mode = 1'b0;
  endtask

  task automatic read_back(input logic [7:0] idx, output logic [31:0] rd);
    logic f;
    access(1'b0, idx, '0, 2'd0, 1'b0, f, rd);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    chk("R8 nx after reset", {31'b0, nx_enable}, 32'd0);
    read_back(EFR, rd); chk("R8 efr reset", rd, 32'd0);
    read_back(MEN, rd); chk("R8 men reset", rd, 32'd0);
  endtask

  task automatic t_legal;
    logic f; logic [31:0] rd;
    access(1'b1, EFR, 32'h0000_0801, 2'd0, 1'b0, f, rd);
    chk("R7 legal write no fault", {31'b0, f}, 32'd0);
    chk("R7 write rd_data zero", rd, 32'd0);
    chk("R8 nx set", {31'b0, nx_enable}, 32'd1);
    read_back(EFR, rd); chk("R7 efr read", rd, 32'h0000_0801);
    access(1'b1, MEN, 32'h0000_00A5, 2'd0, 1'b0, f, rd);
    read_back(MEN, rd); chk("R7 men read", rd, 32'h0000_00A5);
  endtask

  task automatic t_reserved;
    logic f; logic [31:0] rd;
    access(1'b1, EFR, 32'h0000_0002, 2'd0, 1'b0, f, rd);
    chk("R4 efr reserved bit fault", {31'b0, f}, 32'd1);
    chk("R6 fault rd zero", rd, 32'd0);
    chk("R5 nx kept", {31'b0, nx_enable}, 32'd1);
    read_back(EFR, rd); chk("R5 efr unchanged", rd, 32'h0000_0801);
    access(1'b1, MEN, 32'h0000_0100, 2'd0, 1'b0, f, rd);
    chk("R4 men reserved bit fault", {31'b0, f}, 32'd1);
    read_back(MEN, rd); chk("R5 men unchanged", rd, 32'h0000_00A5);
  endtask

  task automatic t_priv;
    logic f; logic [31:0] rd;
    access(1'b0, MEN, '0, 2'd3, 1'b0, f, rd);
    chk("R1 pl3 read fault", {31'b0, f}, 32'd1);
    chk("R6 pl3 read zero", rd, 32'd0);
    access(1'b1, EFR, 32'h0, 2'd1, 1'b0, f, rd);
    chk("R1 pl1 write fault", {31'b0, f}, 32'd1);
    chk("R5 nx kept after pl1", {31'b0, nx_enable}, 32'd1);
    read_back(EFR, rd); chk("R5 efr kept after pl1", rd, 32'h0000_0801);
  endtask

  task automatic t_v86;
    logic f; logic [31:0] rd;
    access(1'b1, MEN, 32'h0000_0011, 2'd0, 1'b1, f, rd);
    chk("R2 v86 write fault", {31'b0, f}, 32'd1);
    read_back(MEN, rd); chk("R5 men kept after v86", rd, 32'h0000_00A5);
    access(1'b0, EFR, '0, 2'd0, 1'b1, f, rd);
    chk("R2 v86 read fault", {31'b0, f}, 32'd1);
    chk("R6 v86 read zero", rd, 32'd0);
  endtask

  task automatic t_unimpl;
    logic f; logic [31:0] rd;
    access(1'b0, 8'h10, '0, 2'd0, 1'b0, f, rd);
    chk("R3 unimpl read fault", {31'b0, f}, 32'd1);
    chk("R6 unimpl read zero", rd, 32'd0);
    access(1'b1, 8'h81, 32'h0, 2'd0, 1'b0, f, rd);
    chk("R3 unimpl write fault", {31'b0, f}, 32'd1);
  endtask

  task automatic t_idle_clear;
    logic f; logic [31:0] rd;
    @(negedge clk);
    req_index = 8'h10; req_write = 1'b1; req_wdata = 32'hFFFF_FFFF; cur_pl = 2'd3;
    #2;
    chk("R9 idle no fault", {31'b0, gp_fault}, 32'd0);
    chk("R9 idle rd zero", rd_data, 32'd0);
    @(negedge clk);
    req_write = 1'b0; req_wdata = '0; cur_pl = 2'd0;
    access(1'b1, EFR, 32'h0000_0001, 2'd0, 1'b0, f, rd);
    chk("R8 nx cleared", {31'b0, nx_enable}, 32'd0);
    read_back(EFR, rd); chk("R7 efr bit0 only", rd, 32'h0000_0001);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
    req_wdata = '0; cur_pl = 2'd0; v86_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_legal;
    t_reserved;
    t_priv;
    t_v86;
    t_unimpl;
    t_idle_clear;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule